// File: doc/BRIEF.md
# LED Column-Driver Configuration Sequencer

This controller performs the power-up configuration of a chain of shift-register LED column drivers on a parallel RGB matrix panel. A single `start` request launches a fixed pin sequence on the six colour data lines, the shift clock, the latch and the active-low output enable. Each 16-bit control word is broadcast on all six data lines and repeated along the whole row, so every driver in the chain is loaded at once. Each driver decides which internal register receives the word by counting how many of the final shift clocks see the latch high.

The `family` input picks one of two driver families. Each family has its own sequence of passes and its own control words. The shift clock is derived from the system clock. Each low phase and each high phase lasts `div`+1 system cycles. Data, latch and enable change only at the start of a low phase, so they are stable for a full half-period before the rising edge that captures them. `done` pulses once at the end of the sequence. After that the pins rest with the clock, latch and data low and the display enabled.

Top module: `led_cfg_seq`

## Requirements
- R1: In the cycle after `start` is taken from idle, `busy` is high, `oe_n` is high and `sclk`, `latch` and `data_out` are low. They stay that way for one setup half-period.
- R2: Inside any row pass, the value on all six data lines at the rising edge of shift clock l is bit 15-(l mod 16) of the pass word, so the most significant bit goes first. All six lines always carry the same value.
- R3: Family 0 (`family`=0) sends the following passes, for a total of 3·ROW_PIXELS+2 clocks:
  - word 0x07E0 with the latch high for the final 11 clocks;
  - word 0x0200 with the latch high for the final 12 clocks;
  - a blank row with the latch low;
  - one clock with the latch high;
  - one clock with `oe_n` low.
- R4: Family 1 sends the following passes, for a total of 4·ROW_PIXELS+2 clocks:
  - a blank row with the latch high for the final 3 clocks;
  - word 0x00FF with the latch high for the final 11 clocks;
  - word 0xFF00 with the latch high for the final 12 clocks;
  - one clock with the latch low;
  - a blank row with the latch high for the final 3 clocks;
  - one clock with `oe_n` low.
- R5: Every high and low phase of `sclk` after setup lasts `div`+1 system cycles. Data, latch and `oe_n` never change in the cycle where `sclk` rises, and the latch only rises while `sclk` is low.
- R6: A `start` that arrives while `busy` is high is ignored. The running sequence carries on unchanged.
- R7: `done` is high for exactly one cycle, in the cycle after the last clock falls. In that cycle, and until the next start, `busy`, `sclk`, `latch` and `data_out` are low and `oe_n` is low.
- R8: Synchronous reset forces `busy` and `done` low, `sclk`, `latch` and `data_out` low and `oe_n` high. A sequence cut short by reset does not resume.
- R9: `family` and `div` are sampled only when `start` is taken. Changing them during a sequence has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the sequence when idle |
| family | input | 1 | Driver family select, sampled at start |
| div | input | DIV_W | Half-period of the shift clock minus one, in system cycles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| data_out | output | 6 | Colour data lines, all carrying the same bit |
| sclk | output | 1 | Panel shift clock |
| latch | output | 1 | Driver latch |
| oe_n | output | 1 | Output enable, active low |

## Verification
The assertions assume that `rst` and `start` are synchronous levels sampled on the rising system edge. They also assume `family` and `div` matter only in the cycle where `start` is taken. The bench drives every input at the falling edge and holds `start` for a single cycle. It keeps `div` small enough that a full sequence fits the run. It changes `family` and `div` and pulses `start` again in the middle of a run, which exercises the sampling rule without breaking what the properties rely on. Reset is applied in the middle of a sequence only as a synchronous pulse of whole cycles.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN} lcs_state_t;

  localparam int PASS_W = 3;

  typedef struct packed {
    logic [15:0] word;     // control word broadcast in this pass
    logic        short1;   // pass is a single clock instead of a full row
    logic [3:0]  tail;     // trailing clocks with the latch high
    logic        oe_on;    // display enabled during this pass
    logic        last;     // final pass of the family
  } pass_t;

  // Pass table: family 0 has passes 0..4, family 1 has passes 0..5.
  function automatic pass_t pass_lookup(input logic fam, input logic [PASS_W-1:0] p);
    pass_t r;
    r = '{word: 16'h0000, short1: 1'b0, tail: 4'd0, oe_on: 1'b0, last: 1'b0};
    if (!fam) begin
      case (p)
        3'd0: begin r.word = 16'h07E0; r.tail = 4'd11; end
        3'd1: begin r.word = 16'h0200; r.tail = 4'd12; end
        3'd2: ;
        3'd3: begin r.short1 = 1'b1; r.tail = 4'd1; end
        default: begin r.short1 = 1'b1; r.oe_on = 1'b1; r.last = 1'b1; end
      endcase
    end else begin
      case (p)
        3'd0: r.tail = 4'd3;
        3'd1: begin r.word = 16'h00FF; r.tail = 4'd11; end
        3'd2: begin r.word = 16'hFF00; r.tail = 4'd12; end
        3'd3: r.short1 = 1'b1;
        3'd4: r.tail = 4'd3;
        default: begin r.short1 = 1'b1; r.oe_on = 1'b1; r.last = 1'b1; end
      endcase
    end
    return r;
  endfunction

  function automatic logic [15:0] pass_word(input logic fam, input logic [PASS_W-1:0] p);
    pass_t r;
    r = pass_lookup(fam, p);
    return r.word;
  endfunction

  function automatic logic [3:0] pass_tail(input logic fam, input logic [PASS_W-1:0] p);
    pass_t r;
    r = pass_lookup(fam, p);
    return r.tail;
  endfunction

  function automatic logic pass_short(input logic fam, input logic [PASS_W-1:0] p);
    pass_t r;
    r = pass_lookup(fam, p);
    return r.short1;
  endfunction

  function automatic logic pass_oe_on(input logic fam, input logic [PASS_W-1:0] p);
    pass_t r;
    r = pass_lookup(fam, p);
    return r.oe_on;
  endfunction

  function automatic logic pass_last(input logic fam, input logic [PASS_W-1:0] p);
    pass_t r;
    r = pass_lookup(fam, p);
    return r.last;
  endfunction

  // Word bit shown at clock position pos (mod 16): MSB first.
  function automatic logic shift_bit(input logic [15:0] w, input logic [3:0] pos);
    return w[4'd15 - pos];
  endfunction

  // Latch window: the final `tail` clocks of a pass of `len` clocks.
  function automatic logic in_tail(input int unsigned idx, input int unsigned len,
                                   input int unsigned tail);
    return (tail != 0) && (idx + tail >= len);
  endfunction

endpackage

// File: rtl/lcs_tick.sv
module lcs_tick #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en)          cnt_q <= half;
    else if (cnt_q == '0)    cnt_q <= half;
    else                     cnt_q <= cnt_q - 1'b1;
  end

  assign tick = en && (cnt_q == '0);
endmodule

// File: rtl/lcs_walker.sv
module lcs_walker
  import lcs_pkg::*;
#(
  parameter int ROW_PIXELS = 64,
  parameter int IDX_W      = 7,
  parameter int DIV_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fam_in,
  input  logic [DIV_W-1:0]  div_in,
  input  logic              tick,
  output lcs_state_t        nxt_state,
  output logic [PASS_W-1:0] nxt_pass,
  output logic [IDX_W-1:0]  nxt_idx,
  output logic              nxt_phase,
  output logic              fam_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              busy,
  output logic              pass_end,
  output logic              seq_end,
  output logic              done
);
  lcs_state_t        state_q;
  logic [PASS_W-1:0] pass_q;
  logic [IDX_W-1:0]  idx_q;
  logic              phase_q;
  logic              done_q;
  int unsigned       cur_len;

  assign cur_len = pass_short(fam_q, pass_q) ? 1 : ROW_PIXELS;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;

  always_comb begin
    nxt_state = state_q;
    nxt_pass  = pass_q;
    nxt_idx   = idx_q;
    nxt_phase = phase_q;
    pass_end  = 1'b0;
    seq_end   = 1'b0;
    case (state_q)
      ST_IDLE: if (start) nxt_state = ST_SETUP;
      ST_SETUP: if (tick) begin
        nxt_state = ST_RUN;
        nxt_pass  = '0;
        nxt_idx   = '0;
        nxt_phase = 1'b0;
      end
      default: if (tick) begin
        if (!phase_q) begin
          nxt_phase = 1'b1;
        end else if (idx_q == IDX_W'(cur_len - 1)) begin
          pass_end  = 1'b1;
          nxt_phase = 1'b0;
          nxt_idx   = '0;
          if (pass_last(fam_q, pass_q)) begin
            seq_end   = 1'b1;
            nxt_state = ST_IDLE;
            nxt_pass  = '0;
          end else begin
            nxt_pass = pass_q + 1'b1;
          end
        end else begin
          nxt_idx   = idx_q + 1'b1;
          nxt_phase = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      idx_q   <= '0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      fam_q   <= 1'b0;
      div_q   <= '0;
    end else begin
      state_q <= nxt_state;
      pass_q  <= nxt_pass;
      idx_q   <= nxt_idx;
      phase_q <= nxt_phase;
      done_q  <= seq_end;
      if (state_q == ST_IDLE && start) begin
        fam_q <= fam_in;
        div_q <= div_in;
      end
    end
  end
endmodule

// File: rtl/lcs_pins.sv
module lcs_pins
  import lcs_pkg::*;
#(
  parameter int ROW_PIXELS = 64,
  parameter int IDX_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  lcs_state_t        nxt_state,
  input  logic              fam,
  input  logic [PASS_W-1:0] nxt_pass,
  input  logic [IDX_W-1:0]  nxt_idx,
  input  logic              nxt_phase,
  output logic [5:0]        data_out,
  output logic              sclk,
  output logic              latch,
  output logic              oe_n
);
  logic [5:0]  data_d;
  logic        sclk_d, latch_d, oe_n_d;
  int unsigned len;

  assign len = pass_short(fam, nxt_pass) ? 1 : ROW_PIXELS;

  always_comb begin
    data_d  = '0;
    sclk_d  = 1'b0;
    latch_d = 1'b0;
    oe_n_d  = oe_n;
    case (nxt_state)
      ST_IDLE:  ;
      ST_SETUP: oe_n_d = 1'b1;
      default: begin
        data_d  = {6{shift_bit(pass_word(fam, nxt_pass), nxt_idx[3:0])}};
        sclk_d  = nxt_phase;
        latch_d = in_tail(32'(nxt_idx), len, 32'(pass_tail(fam, nxt_pass)));
        oe_n_d  = !pass_oe_on(fam, nxt_pass);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      sclk     <= 1'b0;
      latch    <= 1'b0;
      oe_n     <= 1'b1;
    end else begin
      data_out <= data_d;
      sclk     <= sclk_d;
      latch    <= latch_d;
      oe_n     <= oe_n_d;
    end
  end
endmodule

// File: rtl/led_cfg_seq.sv
module led_cfg_seq
  import lcs_pkg::*;
#(
  parameter int ROW_PIXELS = 64,
  parameter int DIV_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             family,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             done,
  output logic [5:0]       data_out,
  output logic             sclk,
  output logic             latch,
  output logic             oe_n
);
  localparam int IDX_W = $clog2(ROW_PIXELS + 1);

  generate
    if (ROW_PIXELS < 16) begin : g_row_check
      $error("ROW_PIXELS must be at least 16");
    end
  endgenerate

  lcs_state_t        nxt_state;
  logic [PASS_W-1:0] nxt_pass;
  logic [IDX_W-1:0]  nxt_idx;
  logic              nxt_phase;
  logic              fam_q;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  half_sel;
  logic              tick;
  logic              pass_end;
  logic              seq_end;

  // While idle the divider preloads the live input, so the setup phase
  // already runs at the rate captured with start.
  assign half_sel = busy ? div_q : div;

  lcs_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(busy), .half(half_sel), .tick(tick)
  );

  lcs_walker #(.ROW_PIXELS(ROW_PIXELS), .IDX_W(IDX_W), .DIV_W(DIV_W)) u_walk (
    .clk(clk), .rst(rst), .start(start), .fam_in(family), .div_in(div), .tick(tick),
    .nxt_state(nxt_state), .nxt_pass(nxt_pass), .nxt_idx(nxt_idx), .nxt_phase(nxt_phase),
    .fam_q(fam_q), .div_q(div_q), .busy(busy), .pass_end(pass_end), .seq_end(seq_end),
    .done(done)
  );

  lcs_pins #(.ROW_PIXELS(ROW_PIXELS), .IDX_W(IDX_W)) u_pins (
    .clk(clk), .rst(rst), .nxt_state(nxt_state), .fam(fam_q), .nxt_pass(nxt_pass),
    .nxt_idx(nxt_idx), .nxt_phase(nxt_phase), .data_out(data_out), .sclk(sclk),
    .latch(latch), .oe_n(oe_n)
  );
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [5:0] data_out,
  input logic       sclk,
  input logic       latch,
  input logic       oe_n,
  input logic       fam_q,
  input logic       pass_end,
  input logic       seq_end
);
  assert_setup_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (oe_n && !sclk && !latch && data_out == 6'd0));

  assert_lines_equal_R2: assert property (@(posedge clk) disable iff (rst)
    (data_out == 6'd0) || (data_out == 6'h3F));

  assert_edge_stable_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> ($stable(data_out) && $stable(latch) && $stable(oe_n)));

  assert_latch_low_phase_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(latch) |-> !sclk);

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !seq_end) |=> (busy && $stable(fam_q)));

  assert_end_done_R7: assert property (@(posedge clk) disable iff (rst)
    seq_end |=> done);

  assert_seq_end_on_pass_R7: assert property (@(posedge clk) disable iff (rst)
    seq_end |-> pass_end);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !oe_n && !sclk && !latch && data_out == 6'd0));

  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (!busy && !done && oe_n && !sclk && !latch && data_out == 6'd0));
endmodule

bind led_cfg_seq lcs_checker u_lcs_checker (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .data_out(data_out),
  .sclk(sclk), .latch(latch), .oe_n(oe_n), .fam_q(fam_q), .pass_end(pass_end),
  .seq_end(seq_end)
);

// File: tb/tb_led_cfg_seq.sv
module tb_led_cfg_seq;
  localparam int ROW   = 64;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             family = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic             busy, done, sclk, latch, oe_n;
  logic [5:0]       data_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  led_cfg_seq #(.ROW_PIXELS(ROW), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst(rst), .start(start), .family(family), .div(div),
    .busy(busy), .done(done), .data_out(data_out), .sclk(sclk), .latch(latch), .oe_n(oe_n)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected {data bit, latch, oe_n} at the rising edge of global clock k.
  function automatic logic [2:0] exp_pins(input bit fam, input int k);
    logic [15:0] w;
    int tl;
    int p;
    w = 16'h0; tl = 0; p = 0;
    if (k < 3 * ROW) begin
      p = k % ROW;
      case (k / ROW)
        0: begin w = fam ? 16'h0000 : 16'h07E0; tl = fam ? 3 : 11; end
        1: begin w = fam ? 16'h00FF : 16'h0200; tl = fam ? 11 : 12; end
        default: begin w = fam ? 16'hFF00 : 16'h0000; tl = fam ? 12 : 0; end
      endcase
    end else if (!fam) begin
      if (k == 3 * ROW) return 3'b011;
      return 3'b000;
    end else begin
      if (k == 3 * ROW) return 3'b001;
      if (k > 4 * ROW) return 3'b000;
      p = k - 3 * ROW - 1; w = 16'h0; tl = 3;
    end
    return {((w << (p % 16)) & 16'h8000) != 16'h0, p >= ROW - tl, 1'b1};
  endfunction

  function automatic int exp_total(input bit fam);
    return fam ? 4 * ROW + 2 : 3 * ROW + 2;
  endfunction

  task automatic idle_pins(input string req, input bit oe_exp);
    chk(busy == 1'b0, req, "busy", busy, 0);
    chk(sclk == 1'b0 && latch == 1'b0 && data_out == 6'd0, req, "sclk/latch/data",
        {sclk, latch, data_out}, 0);
    chk(oe_n == oe_exp, req, "oe_n", oe_n, oe_exp);
  endtask

  task automatic run_seq(input bit fam, input int dv, input bit poke);
    int k;
    int runlen;
    int guard;
    bit prev;
    bit poked;
    logic [2:0] e;
    string rq;
    rq = fam ? "R4" : "R3";
    @(negedge clk);
    family = fam; div = DIV_W'(dv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: setup state one cycle after start
    chk(busy == 1'b1, "R1", "busy", busy, 1);
    chk(oe_n == 1'b1, "R1", "oe_n", oe_n, 1);
    chk(sclk == 1'b0 && latch == 1'b0 && data_out == 6'd0, "R1", "quiet pins",
        {sclk, latch, data_out}, 0);
    if (poke) begin
      family = ~fam;                    // R9: must not matter after start
      div = DIV_W'((dv + 1) % 4);
    end
    k = 0; runlen = 1; prev = 1'b0; poked = 1'b0; guard = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      guard++;
      if (sclk != prev) begin
        if (sclk) begin
          e = exp_pins(fam, k);
          chk(data_out == {6{e[2]}}, "R2", $sformatf("data at clock %0d", k), data_out, {6{e[2]}});
          chk(latch == e[1], rq, $sformatf("latch at clock %0d", k), latch, e[1]);
          chk(oe_n == e[0], rq, $sformatf("oe_n at clock %0d", k), oe_n, e[0]);
          if (k > 0) chk(runlen == dv + 1, "R5", "low phase length", runlen, dv + 1);
          k++;
        end else begin
          chk(runlen == dv + 1, "R5", "high phase length", runlen, dv + 1);
        end
        runlen = 1;
        prev = sclk;
      end else begin
        runlen++;
      end
      if (poke && !poked && k == 5) begin
        start = 1'b1;                   // R6: start while busy is ignored
        poked = 1'b1;
      end
      if (done) break;
      if (guard > 20000) begin
        chk(1'b0, rq, "sequence timeout", guard, 0);
        break;
      end
    end
    start = 1'b0;
    chk(k == exp_total(fam), rq, "clock count (R6/R9 when poked)", k, exp_total(fam));
    idle_pins("R7", 1'b0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", done, 0);
    repeat (4) @(negedge clk);
    idle_pins("R7", 1'b0);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    idle_pins("R8", 1'b1);
    chk(done == 1'b0, "R8", "done after reset", done, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Directed corners
    run_seq(1'b0, 0, 1'b0);
    run_seq(1'b1, 0, 1'b0);
    run_seq(1'b1, 2, 1'b1);
    run_seq(1'b0, 3, 1'b1);

    // R8: reset in the middle of a sequence
    @(negedge clk);
    family = 1'b1; div = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    idle_pins("R8", 1'b1);
    chk(done == 1'b0, "R8", "done during reset", done, 0);
    rst = 1'b0;
    repeat (50) @(negedge clk);
    idle_pins("R8", 1'b1);

    // Constrained random runs
    for (int i = 0; i < 5; i++) begin
      bit f;
      int d;
      bit pk;
      f  = 1'($urandom % 2);
      d  = int'($urandom % 4);
      pk = 1'($urandom % 2);
      run_seq(f, d, pk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule